// File: doc/BRIEF.md
# Wide Operand Memory Access Sequencer

This block turns one operand request into a sequence of 32-bit memory beats. A request carries a 6-bit addressing field, a size code and a direction. The field's upper three bits pick an addressing mode and its lower three bits pick a register. The block fetches any extension words the mode needs from a 16-bit extension-word stream. It then forms the effective address, runs one, two or three beats on a valid/ready memory port, and finishes with a one-cycle `done` pulse. On that pulse it also writes back the address register for the auto-increment and auto-decrement modes.

The register files stay outside the block. The block drives a register index and reads the selected value back combinationally. A write to an address register or a data register is an indexed write strobe that coincides with `done`. A load returns a 64-bit value. A store takes a 64-bit value and emits it high word first.

The size codes are 0 for 32 bits (one beat), 1 for 64 bits (two beats) and 2 for 96 bits (three beats). Code 3 is reserved. `req_write` = 1 means a store and 0 means a load.

Top module: `wide_opnd_seq`

## Requirements
- R1: Addressing mode comes from `req_ea[5:3]` and the register number from `req_ea[2:0]`. Only the register named by bits 2:0 is read or written back; all other registers keep their values.
- R2: Mode 2 (register indirect) issues its beats at An, An+4 and An+8, in that order. An is not written back.
- R3: Mode 3 (postincrement) uses the original An as the first beat address. It then writes back An plus 4, 8 or 12 for size 0, 1 or 2.
- R4: Mode 4 (predecrement) first subtracts 4, 8 or 12 from An. The reduced value is the first beat address and is also the value written back.
- R5: Mode 5 (displacement) consumes exactly one extension word. The first beat goes to An plus that word sign-extended to 32 bits, and An is not written back.
- R6: Mode 7 with register field 1 (absolute long) consumes two extension words. The first word received is the upper half of the address and the second is the lower half.
- R7: Load data for size 0 is the single word zero-extended to 64 bits. For sizes 1 and 2, the first beat's word becomes bits 63:32 and the second beat's word becomes bits 31:0; the third word of a size-2 load is discarded.
- R8: Store beats for size 0 carry `req_wdata[31:0]`. For size 1 they carry bits 63:32, then bits 31:0. For size 2 they carry bits 63:32, then bits 31:0, then zero. `mem_write` is high on every store beat and low on every load beat.
- R9: Mode 0 (size 0 only) makes no memory access. A load returns the selected data register zero-extended. A store writes `req_wdata[31:0]` into that data register.
- R10: A beat holds its address and data until `mem_ready` is sampled high. `done` pulses for exactly one cycle, one cycle after the last beat is accepted, or one cycle after a mode-0 request is accepted. `req_ready` is high only while idle.
- R11: Any of the following pulses `err` for one cycle, one cycle after the request is accepted: mode 1, mode 6, mode 7 with any register other than 1, mode 0 with a size other than 0, or size code 3. It then produces no `done`, no register write, no memory beat and no extension-word consumption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle and accepting a request |
| req_ea | input | 6 | Addressing field: mode in 5:3, register in 2:0 |
| req_size | input | 2 | 0: 32-bit, 1: 64-bit, 2: 96-bit, 3: reserved |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | 64 | Store operand |
| ext_valid | input | 1 | Extension word available |
| ext_ready | output | 1 | Block consumes the extension word this cycle when valid |
| ext_word | input | 16 | Extension word |
| areg_idx | output | 3 | Address register index |
| areg_val | input | 32 | Value of the indexed address register |
| areg_we | output | 1 | Address register write strobe |
| areg_wval | output | 32 | Address register write value |
| dreg_idx | output | 3 | Data register index |
| dreg_val | input | 32 | Value of the indexed data register |
| dreg_we | output | 1 | Data register write strobe |
| dreg_wval | output | 32 | Data register write value |
| mem_valid | output | 1 | Beat request |
| mem_ready | input | 1 | Beat accepted |
| mem_write | output | 1 | Beat direction, 1 for a write |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Beat write data |
| mem_rdata | input | 32 | Beat read data, valid with `mem_ready` |
| done | output | 1 | Operation complete pulse |
| err | output | 1 | Illegal request pulse |
| rd_data | output | 64 | Load result, valid while `done` is high |

## Verification
The hardest case to reach is a long operation that stalls in every phase. An example is an absolute-long or displacement access whose extension words arrive late and whose beats are each held for several cycles, while the register write-back still has to land exactly with the `done` pulse. The bench withholds `ext_valid` and `mem_ready` at random on most cycles, so extension fetches and beats stretch across many waits. It mixes random addressing fields, including the illegal ones, with random register contents. Directed cases cover predecrement and postincrement across the 32-bit wrap, negative displacements, and the discarded third word of a 96-bit load.

// File: rtl/wide_opnd_pkg.sv
package wide_opnd_pkg;

  typedef enum logic [2:0] {
    K_DREG,
    K_IND,
    K_POST,
    K_PRE,
    K_DISP,
    K_ABS,
    K_BAD
  } ea_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXT_A,
    ST_EXT_B,
    ST_CALC,
    ST_XFER,
    ST_FIN,
    ST_FAIL
  } seq_st_e;

  localparam int unsigned MAX_BEATS = 3;
  localparam int unsigned SIZE_W    = 2;
  localparam int unsigned BEAT_CW   = $clog2(MAX_BEATS + 1);

endpackage

// File: rtl/wide_opnd_decode.sv
module wide_opnd_decode
  import wide_opnd_pkg::*;
#(
  parameter int unsigned RIW = 3
) (
  input  logic [2*RIW-1:0]  ea,
  input  logic [SIZE_W-1:0] size,
  output ea_kind_e          kind,
  output logic [RIW-1:0]    reg_no,
  output logic              legal
);

  logic [RIW-1:0] mode;

  assign mode   = ea[2*RIW-1:RIW];
  assign reg_no = ea[RIW-1:0];

  always_comb begin
    kind = K_BAD;
    unique case (mode)
      3'd0:    kind = (size == '0) ? K_DREG : K_BAD;
      3'd2:    kind = K_IND;
      3'd3:    kind = K_POST;
      3'd4:    kind = K_PRE;
      3'd5:    kind = K_DISP;
      3'd7:    kind = (reg_no == 3'd1) ? K_ABS : K_BAD;
      default: kind = K_BAD;
    endcase
    if (size == 2'd3) kind = K_BAD;
  end

  assign legal = (kind != K_BAD);

  always_comb begin
    AST_BAD_MODE_REJECT: assert (!((mode == 3'd1 || mode == 3'd6) && legal)); // R11
  end

endmodule

// File: rtl/wide_opnd_addr.sv
module wide_opnd_addr
  import wide_opnd_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned EW = 16
) (
  input  ea_kind_e          kind,
  input  logic [SIZE_W-1:0] size,
  input  logic [AW-1:0]     an_val,
  input  logic [EW-1:0]     ext_a,
  input  logic [EW-1:0]     ext_b,
  output logic [AW-1:0]     base_addr,
  output logic [AW-1:0]     an_next,
  output logic              an_update
);

  localparam int unsigned PADW = AW - EW;

  logic [AW-1:0] step;
  logic [AW-1:0] disp_sx;
  logic [AW-1:0] abs_addr;

  assign step     = AW'({size, 2'b00}) + AW'(4);
  assign disp_sx  = {{PADW{ext_a[EW-1]}}, ext_a};
  assign abs_addr = AW'({ext_a, ext_b});

  always_comb begin
    base_addr = an_val;
    an_next   = an_val;
    an_update = 1'b0;
    case (kind)
      K_POST: begin
        an_next   = an_val + step;
        an_update = 1'b1;
      end
      K_PRE: begin
        an_next   = an_val - step;
        base_addr = an_val - step;
        an_update = 1'b1;
      end
      K_DISP:  base_addr = an_val + disp_sx;
      K_ABS:   base_addr = abs_addr;
      default: ;
    endcase
  end

  always_comb begin
    AST_PRE_ADDR_IS_WB: assert (!(kind == K_PRE) || (base_addr == an_next)); // R4
  end

endmodule

// File: rtl/wide_opnd_beats.sv
module wide_opnd_beats
  import wide_opnd_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [BEAT_CW-1:0]  nbeats,
  input  logic [DW-1:0]       base,
  input  logic                write,
  input  logic [2*DW-1:0]     wdata,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_write,
  output logic [DW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  output logic                fin,
  output logic [2*DW-1:0]     rdata
);

  logic               act_q, act_d;
  logic [BEAT_CW-1:0] beat_q, beat_d;
  logic [BEAT_CW-1:0] nb_q;
  logic [DW-1:0]      base_q;
  logic               wr_q;
  logic [2*DW-1:0]    wd_q;
  logic [DW-1:0]      hi_q, hi_d, lo_q, lo_d;
  logic               xfer, last;

  assign xfer = act_q & mem_ready;
  assign last = (beat_q == nb_q - BEAT_CW'(1));
  assign fin  = xfer & last;

  always_comb begin
    act_d  = act_q;
    beat_d = beat_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (start) begin
      act_d  = 1'b1;
      beat_d = '0;
      hi_d   = '0;
      lo_d   = '0;
    end else if (xfer) begin
      beat_d = beat_q + BEAT_CW'(1);
      if (last) act_d = 1'b0;
      if (!wr_q) begin
        if (beat_q == '0) begin
          if (nb_q == BEAT_CW'(1)) lo_d = mem_rdata;
          else                     hi_d = mem_rdata;
        end else if (beat_q == BEAT_CW'(1)) begin
          lo_d = mem_rdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      act_q  <= act_d;
      beat_q <= beat_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nb_q   <= '0;
      base_q <= '0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
    end else if (start) begin
      nb_q   <= nbeats;
      base_q <= base;
      wr_q   <= write;
      wd_q   <= wdata;
    end
  end

  always_comb begin
    case (beat_q)
      BEAT_CW'(0): mem_wdata = (nb_q == BEAT_CW'(1)) ? wd_q[DW-1:0] : wd_q[2*DW-1:DW];
      BEAT_CW'(1): mem_wdata = wd_q[DW-1:0];
      default:     mem_wdata = '0;
    endcase
  end

  assign mem_valid = act_q;
  assign mem_write = wr_q;
  assign mem_addr  = base_q + DW'({beat_q, 2'b00});
  assign rdata     = {hi_q, lo_q};

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata)); // R10

  AST_BEAT_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !fin |=> mem_valid && (mem_addr == $past(mem_addr) + DW'(4))); // R2

  AST_THIRD_STORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && (beat_q == BEAT_CW'(2)) |-> (mem_wdata == '0)); // R8

endmodule

// File: rtl/wide_opnd_seq.sv
module wide_opnd_seq
  import wide_opnd_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned EW  = 16,
  parameter int unsigned RIW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2*RIW-1:0]  req_ea,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [2*DW-1:0]   req_wdata,
  input  logic              ext_valid,
  output logic              ext_ready,
  input  logic [EW-1:0]     ext_word,
  output logic [RIW-1:0]    areg_idx,
  input  logic [DW-1:0]     areg_val,
  output logic              areg_we,
  output logic [DW-1:0]     areg_wval,
  output logic [RIW-1:0]    dreg_idx,
  input  logic [DW-1:0]     dreg_val,
  output logic              dreg_we,
  output logic [DW-1:0]     dreg_wval,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              done,
  output logic              err,
  output logic [2*DW-1:0]   rd_data
);

  seq_st_e         st_q, st_d;
  ea_kind_e        dec_kind, kind_q;
  logic [RIW-1:0]  dec_reg, reg_q;
  logic            dec_legal;
  logic [1:0]      size_q;
  logic            write_q;
  logic [2*DW-1:0] wdata_q;
  logic [EW-1:0]   ext_a_q, ext_b_q;
  logic [DW-1:0]   an_wval_q;
  logic            an_upd_q;
  logic            ld_req, ld_ext_a, ld_ext_b, eng_start, eng_fin;
  logic [DW-1:0]   base_addr, an_next;
  logic            an_update;
  logic [2*DW-1:0] eng_rdata;

  wide_opnd_decode #(.RIW(RIW)) u_dec (
    .ea     (req_ea),
    .size   (req_size),
    .kind   (dec_kind),
    .reg_no (dec_reg),
    .legal  (dec_legal)
  );

  wide_opnd_addr #(.AW(DW), .EW(EW)) u_addr (
    .kind      (kind_q),
    .size      (size_q),
    .an_val    (areg_val),
    .ext_a     (ext_a_q),
    .ext_b     (ext_b_q),
    .base_addr (base_addr),
    .an_next   (an_next),
    .an_update (an_update)
  );

  wide_opnd_beats #(.DW(DW)) u_beats (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (eng_start),
    .nbeats    (BEAT_CW'(size_q) + BEAT_CW'(1)),
    .base      (base_addr),
    .write     (write_q),
    .wdata     (wdata_q),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .fin       (eng_fin),
    .rdata     (eng_rdata)
  );

  always_comb begin
    st_d      = st_q;
    ld_req    = 1'b0;
    ld_ext_a  = 1'b0;
    ld_ext_b  = 1'b0;
    eng_start = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req = 1'b1;
          if (!dec_legal) begin
            st_d = ST_FAIL;
          end else begin
            case (dec_kind)
              K_DREG:        st_d = ST_FIN;
              K_DISP, K_ABS: st_d = ST_EXT_A;
              default:       st_d = ST_CALC;
            endcase
          end
        end
      end
      ST_EXT_A: begin
        if (ext_valid) begin
          ld_ext_a = 1'b1;
          st_d     = (kind_q == K_ABS) ? ST_EXT_B : ST_CALC;
        end
      end
      ST_EXT_B: begin
        if (ext_valid) begin
          ld_ext_b = 1'b1;
          st_d     = ST_CALC;
        end
      end
      ST_CALC: begin
        eng_start = 1'b1;
        st_d      = ST_XFER;
      end
      ST_XFER: if (eng_fin) st_d = ST_FIN;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_BAD;
      reg_q   <= '0;
      size_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (ld_req) begin
      kind_q  <= dec_kind;
      reg_q   <= dec_reg;
      size_q  <= req_size;
      write_q <= req_write;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ext_a_q <= '0;
    else if (ld_ext_a) ext_a_q <= ext_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ext_b_q <= '0;
    else if (ld_ext_b) ext_b_q <= ext_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      an_wval_q <= '0;
      an_upd_q  <= 1'b0;
    end else if (ld_req) begin
      an_upd_q  <= 1'b0;
    end else if (eng_start) begin
      an_wval_q <= an_next;
      an_upd_q  <= an_update;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign ext_ready = (st_q == ST_EXT_A) || (st_q == ST_EXT_B);
  assign areg_idx  = reg_q;
  assign dreg_idx  = reg_q;
  assign done      = (st_q == ST_FIN);
  assign err       = (st_q == ST_FAIL);
  assign areg_we   = done && an_upd_q;
  assign areg_wval = an_wval_q;
  assign dreg_we   = done && (kind_q == K_DREG) && write_q;
  assign dreg_wval = wdata_q[DW-1:0];
  assign rd_data   = (kind_q == K_DREG) ? {{DW{1'b0}}, dreg_val} : eng_rdata;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_valid && !areg_we && !dreg_we && !done && !ext_ready); // R11

  AST_DREG_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && kind_q == K_DREG) |-> !mem_valid); // R9

  AST_WB_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    areg_we |-> (kind_q == K_POST || kind_q == K_PRE)); // R3

  AST_ABS_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXT_B) |-> (kind_q == K_ABS)); // R6

endmodule

// File: tb/sim_wide_opnd_seq.sv
module sim_wide_opnd_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_ea = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        ext_valid = 1'b0;
  logic        ext_ready;
  logic [15:0] ext_word;
  logic [2:0]  areg_idx, dreg_idx;
  logic [31:0] areg_val, dreg_val, areg_wval, dreg_wval;
  logic        areg_we, dreg_we;
  logic        mem_valid, mem_write, done, err;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [63:0] rd_data;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  int unsigned stall_pct = 50;

  logic [31:0] areg_m [8];
  logic [31:0] dreg_m [8];
  logic        pk_en = 1'b0;
  logic        pk_isa = 1'b0;
  logic [2:0]  pk_idx = '0;
  logic [31:0] pk_val = '0;
  logic [15:0] ext_q [4];
  logic [1:0]  ext_ptr;
  int unsigned lg_n;
  logic [31:0] lg_a [16];
  logic [31:0] lg_d [16];
  logic        lg_w [16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  wide_opnd_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_word(ext_word),
    .areg_idx(areg_idx), .areg_val(areg_val), .areg_we(areg_we), .areg_wval(areg_wval),
    .dreg_idx(dreg_idx), .dreg_val(dreg_val), .dreg_we(dreg_we), .dreg_wval(dreg_wval),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .err(err), .rd_data(rd_data)
  );

  function automatic logic [31:0] mdat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  assign mem_rdata = mdat(mem_addr);
  assign areg_val  = areg_m[areg_idx];
  assign dreg_val  = dreg_m[dreg_idx];
  assign ext_word  = ext_q[ext_ptr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_ptr <= '0;
      lg_n    <= 0;
      for (int i = 0; i < 8; i++) begin
        areg_m[i] <= 32'h1000 * (i + 1);
        dreg_m[i] <= 32'hD000 + i;
      end
    end else begin
      if (pk_en && pk_isa)  areg_m[pk_idx] <= pk_val;
      if (pk_en && !pk_isa) dreg_m[pk_idx] <= pk_val;
      if (areg_we) areg_m[areg_idx] <= areg_wval;
      if (dreg_we) dreg_m[dreg_idx] <= dreg_wval;
      if (ext_valid && ext_ready) ext_ptr <= ext_ptr + 2'd1;
      if (mem_valid && mem_ready) begin
        lg_a[lg_n % 16] <= mem_addr;
        lg_d[lg_n % 16] <= mem_wdata;
        lg_w[lg_n % 16] <= mem_write;
        lg_n <= lg_n + 1;
      end
    end
  end

  always @(negedge clk) begin
    mem_ready <= (($urandom % 100) >= stall_pct);
    ext_valid <= (($urandom % 100) >= stall_pct);
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input bit isa, input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    pk_en = 1'b1; pk_isa = isa; pk_idx = idx; pk_val = val;
    @(negedge clk);
    pk_en = 1'b0;
  endtask

  function automatic bit legal(input logic [5:0] ea, input logic [1:0] sz);
    if (sz == 2'd3) return 1'b0;
    case (ea[5:3])
      3'd0:    return sz == 2'd0;
      3'd2, 3'd3, 3'd4, 3'd5: return 1'b1;
      3'd7:    return ea[2:0] == 3'd1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_op(input logic [5:0] ea, input logic [1:0] sz, input bit wr,
                        input logic [63:0] wd, input logic [15:0] e0, input logic [15:0] e1);
    logic [31:0] a_snap [8];
    logic [31:0] d_snap [8];
    logic [31:0] step, base, an_exp;
    logic [63:0] rd_exp, got_rd;
    logic [1:0]  p0;
    int unsigned l0, nb, next_exp;
    bit          ok_leg, got_done, got_err, seen;
    string       atag;
    logic [2:0]  md, rg;
    md = ea[5:3]; rg = ea[2:0];
    @(negedge clk);
    p0 = ext_ptr;
    ext_q[p0] = e0;
    ext_q[p0 + 2'd1] = e1;
    l0 = lg_n;
    for (int i = 0; i < 8; i++) begin a_snap[i] = areg_m[i]; d_snap[i] = dreg_m[i]; end
    ok_leg = legal(ea, sz);
    step = 32'd4 * (sz + 1);
    nb = sz + 1;
    base = a_snap[rg]; an_exp = a_snap[rg]; atag = "R2";
    case (md)
      3'd3: begin an_exp = base + step; atag = "R3"; end
      3'd4: begin base = base - step; an_exp = base; atag = "R4"; end
      3'd5: begin base = base + {{16{e0[15]}}, e0}; atag = "R5"; end
      3'd7: begin base = {e0, e1}; atag = "R6"; end
      default: ;
    endcase
    if (md == 3'd0) rd_exp = {32'd0, d_snap[rg]};
    else if (sz == 2'd0) rd_exp = {32'd0, mdat(base)};
    else rd_exp = {mdat(base), mdat(base + 32'd4)};
    req_ea = ea; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 1'b0; got_done = 1'b0; got_err = 1'b0; got_rd = '0;
    for (int c = 0; c < 400 && !seen; c++) begin
      if (c != 0) @(negedge clk);
      if (done || err) begin
        seen = 1'b1; got_done = done; got_err = err; got_rd = rd_data;
      end
    end
    @(negedge clk);
    chk(seen, "R10 completion", {63'd0, seen}, 64'd1);
    chk(got_done == 1'b0 && got_err == 1'b0 || done == 1'b0, "R10 done pulse width", {63'd0, done}, 64'd0);
    if (!ok_leg) begin
      chk(got_err && !got_done, "R11 err not done", {62'd0, got_err, got_done}, 64'd2);
      chk(lg_n == l0, "R11 no beats", 64'(lg_n - l0), 64'd0);
      chk(ext_ptr == p0, "R11 no ext", {62'd0, ext_ptr}, {62'd0, p0});
      for (int i = 0; i < 8; i++) begin
        chk(areg_m[i] == a_snap[i] && dreg_m[i] == d_snap[i], "R11 regs kept",
            {areg_m[i], dreg_m[i]}, {a_snap[i], d_snap[i]});
      end
      return;
    end
    chk(got_done && !got_err, "R10 done not err", {62'd0, got_err, got_done}, 64'd1);
    if (md == 3'd0) begin
      chk(lg_n == l0, "R9 no beats", 64'(lg_n - l0), 64'd0);
      if (wr) chk(dreg_m[rg] == wd[31:0], "R9 dreg write", {32'd0, dreg_m[rg]}, {32'd0, wd[31:0]});
      else    chk(got_rd == rd_exp, "R9 dreg read", got_rd, rd_exp);
      for (int i = 0; i < 8; i++) begin
        if (i != rg || !wr)
          chk(dreg_m[i] == d_snap[i], "R1 other dreg kept", {32'd0, dreg_m[i]}, {32'd0, d_snap[i]});
        chk(areg_m[i] == a_snap[i], "R9 areg kept", {32'd0, areg_m[i]}, {32'd0, a_snap[i]});
      end
      return;
    end
    chk(lg_n - l0 == nb, "R10 beat count", 64'(lg_n - l0), 64'(nb));
    for (int b = 0; b < 3; b++) begin
      if (b < nb) begin
        logic [31:0] wexp;
        wexp = (b == 2) ? 32'd0 : (b == 1) ? wd[31:0] : (sz == 2'd0) ? wd[31:0] : wd[63:32];
        chk(lg_a[(l0 + b) % 16] == base + 32'd4 * b, atag,
            {32'd0, lg_a[(l0 + b) % 16]}, {32'd0, base + 32'd4 * b});
        chk(lg_w[(l0 + b) % 16] == wr, "R8 direction", {63'd0, lg_w[(l0 + b) % 16]}, {63'd0, wr});
        if (wr) chk(lg_d[(l0 + b) % 16] == wexp, "R8 store beat",
                    {32'd0, lg_d[(l0 + b) % 16]}, {32'd0, wexp});
      end
    end
    if (!wr) chk(got_rd == rd_exp, "R7 load data", got_rd, rd_exp);
    next_exp = (md == 3'd5) ? 1 : (md == 3'd7) ? 2 : 0;
    chk(ext_ptr == p0 + 2'(next_exp), (md == 3'd7) ? "R6 ext count" : "R5 ext count",
        {62'd0, ext_ptr}, {62'd0, p0 + 2'(next_exp)});
    chk(areg_m[rg] == an_exp, atag, {32'd0, areg_m[rg]}, {32'd0, an_exp});
    for (int i = 0; i < 8; i++) begin
      if (i != rg)
        chk(areg_m[i] == a_snap[i], "R1 other areg kept", {32'd0, areg_m[i]}, {32'd0, a_snap[i]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired actual=%h expected=%h", 1'b1, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_valid && !done && !err && !areg_we && !dreg_we && !ext_ready,
        "R10 reset state", {57'd0, req_ready, mem_valid, done, err, areg_we, dreg_we, ext_ready},
        {57'd0, 7'b1000000});

    stall_pct = 0;
    run_op({3'd2, 3'd1}, 2'd2, 1'b0, 64'h0, 16'h0, 16'h0);
    run_op({3'd2, 3'd3}, 2'd2, 1'b1, 64'h1122_3344_5566_7788, 16'h0, 16'h0);
    poke(1'b1, 3'd2, 32'hFFFF_FFFC);
    run_op({3'd3, 3'd2}, 2'd1, 1'b0, 64'h0, 16'h0, 16'h0);
    poke(1'b1, 3'd5, 32'h0000_0004);
    run_op({3'd4, 3'd5}, 2'd2, 1'b1, 64'hCAFE_F00D_DEAD_BEEF, 16'h0, 16'h0);
    run_op({3'd5, 3'd6}, 2'd0, 1'b0, 64'h0, 16'h8004, 16'h0);
    run_op({3'd7, 3'd1}, 2'd1, 1'b1, 64'h0123_4567_89AB_CDEF, 16'hABCD, 16'h1230);
    run_op({3'd0, 3'd4}, 2'd0, 1'b0, 64'h0, 16'h0, 16'h0);
    run_op({3'd0, 3'd7}, 2'd0, 1'b1, 64'h0000_0000_7777_1111, 16'h0, 16'h0);
    run_op({3'd0, 3'd1}, 2'd1, 1'b0, 64'h0, 16'h0, 16'h0);
    run_op({3'd1, 3'd0}, 2'd0, 1'b0, 64'h0, 16'h0, 16'h0);
    run_op({3'd6, 3'd2}, 2'd0, 1'b1, 64'h5, 16'h0, 16'h0);
    run_op({3'd7, 3'd4}, 2'd0, 1'b0, 64'h0, 16'h0, 16'h0);
    run_op({3'd2, 3'd0}, 2'd3, 1'b0, 64'h0, 16'h0, 16'h0);

    stall_pct = 60;
    for (int n = 0; n < 300; n++) begin
      logic [2:0] md, rg;
      logic [1:0] sz;
      case ($urandom % 8)
        0: md = 3'd0;
        1: md = 3'd2;
        2: md = 3'd3;
        3: md = 3'd4;
        4: md = 3'd5;
        5: md = 3'd7;
        default: md = 3'($urandom);
      endcase
      rg = (md == 3'd7 && ($urandom % 4) != 0) ? 3'd1 : 3'($urandom);
      sz = (($urandom % 10) == 0) ? 2'd3 : 2'($urandom % 3);
      if (md == 3'd0 && ($urandom % 4) != 0) sz = 2'd0;
      if (($urandom % 4) == 0) poke(1'b1, rg, $urandom);
      if (($urandom % 4) == 0) poke(1'b0, rg, $urandom);
      run_op({md, rg}, sz, 1'($urandom), {$urandom, $urandom}, 16'($urandom), 16'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule